// File: doc/BRIEF.md
# Channel-Indexed Converter Configuration Register Bank

This block is the register file that sits behind the serial control port of a multichannel converter. A serial front end decodes each transaction and hands over a write strobe with a 16-bit address and a data byte. Reads are presented as an address, and the block returns the matching byte combinationally. The block drives the live configuration outputs: power mode, what the power-down pin does, duty-cycle stabilizer control, the committed sample-rate override and the per-channel settings.

The port-configuration byte stores its flags twice, mirrored about the byte centre, so it decodes the same whichever bit order the link uses. A write that sets either soft-reset copy returns every writable register to its default, and the soft-reset bits never read back as set. A channel mask chooses which per-channel copies of a local register take a write. Global registers take no notice of the mask. The sample-rate override is written into a shadow and only reaches the output when a separate transfer strobe is written.

Top module: `cfg_bank_regs`

## Requirements
- R1: Address 0x00 reads 0x18 after reset. Bits 3 and 4 always read 1, and bits 0 and 7 always read 0.
- R2: A write to 0x00 with bit 6 or bit 1 set (and bits 5 and 2 clear) sets the bit-order flag, which then reads at both bit 6 and bit 1. A write with both bits clear clears the flag.
- R3: A write to 0x00 with bit 5 or bit 2 set returns, from the next clock edge, every writable register to its default (0x00 reads 0x18, 0x05 reads 0x3F, 0x08 reads 0x00, 0x09 reads 0x01, and the channel copies, rate shadow and rate_act_o are 0x00). Bits 5 and 2 of 0x00 always read 0.
- R4: Address 0x01 always reads 0xB5. Writes to it change nothing.
- R5: Address 0x02 always reads 0x60 (grade field 3'b110 in bits [6:4]).
- R6: Address 0x05 is the channel mask and resets to 0x3F. Bits [5:0] are writable, and bits [7:6] read 0. Bit n selects channel n: 0 to 3 are data channels A to D, 4 is the frame clock and 5 is the data clock.
- R7: A write to 0x14 updates only the channel copies whose mask bit is set. Copy n appears at chan_cfg_o[8n+7:8n]. A read of 0x14 returns the lowest-numbered selected copy, or 0x00 when the mask is 0.
- R8: Address 0x100 holds the rate-override shadow, which reads back directly. rate_act_o takes the shadow value only on the edge of a write to 0xFF with bit 0 set. Address 0xFF always reads 0x00.
- R9: Address 0x08 drives pwr_mode_o from bits [1:0] (00 run, 01 full power-down, 10 standby, 11 reset) and pdwn_stby_o from bit 5 (0 full power-down, 1 standby). Its other bits read 0, and it resets to 0x00.
- R10: Bit 0 of 0x09 drives dcs_off_o (1 stabilizer off, 0 on). It resets to 0x01, and its other bits read 0.
- R11: Reads from any address not listed above return 0x00.
- R12: Writes to 0x08 and 0x09 take effect whatever the channel mask holds, including a mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 16 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| pwr_mode_o | output | 2 | Active global power mode |
| pdwn_stby_o | output | 1 | Power-down pin selects standby when 1 |
| dcs_off_o | output | 1 | Duty-cycle stabilizer disabled when 1 |
| rate_act_o | output | 8 | Committed sample-rate override |
| chan_cfg_o | output | 48 | Per-channel local settings, 8 bits per channel |

## Verification
Every write lands on the clock edge at which its strobe is sampled. Register contents, the configuration outputs and a soft reset or transfer therefore all take effect one edge after the strobe is driven. Read data has no latency: it follows rd_addr_i within the same cycle. The bench drives strobes on the falling edge and drops them on the next falling edge, so each write is complete when the task returns. It sets the read address on a falling edge and samples one nanosecond later, which keeps every check half a cycle away from the active edge.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned BW = 8;

  localparam logic [15:0] A_PORT  = 16'h0000;
  localparam logic [15:0] A_ID    = 16'h0001;
  localparam logic [15:0] A_GRADE = 16'h0002;
  localparam logic [15:0] A_INDEX = 16'h0005;
  localparam logic [15:0] A_PWR   = 16'h0008;
  localparam logic [15:0] A_CLK   = 16'h0009;
  localparam logic [15:0] A_CHCFG = 16'h0014;
  localparam logic [15:0] A_XFER  = 16'h00FF;
  localparam logic [15:0] A_RATE  = 16'h0100;

  localparam logic [BW-1:0] CHIP_ID    = 8'hB5;
  localparam logic [BW-1:0] GRADE_VAL  = 8'h60;
  localparam logic [BW-1:0] PORT_FIXED = 8'h18;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_OFF  = 2'b01,
    PM_STBY = 2'b10,
    PM_RST  = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank #(
  parameter int unsigned NCH = 6,
  parameter int unsigned DW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              wr_i,
  input  logic [NCH-1:0]    sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NCH*DW-1:0] flat_o,
  output logic [DW-1:0]     rd_o
);
  logic [DW-1:0] copy_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                copy_q[g] <= '0;
      else if (srst_i)            copy_q[g] <= '0;
      else if (wr_i && sel_i[g])  copy_q[g] <= wdata_i;
    end
    assign flat_o[g*DW +: DW] = copy_q[g];
  end

  // lowest selected channel wins
  always_comb begin
    rd_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (sel_i[i]) rd_o = copy_q[i];
    end
  end
endmodule

// File: rtl/cfg_shadow_pair.sv
module cfg_shadow_pair #(
  parameter int unsigned    DW  = 8,
  parameter logic [DW-1:0]  RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          wr_i,
  input  logic          commit_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] shadow_o,
  output logic [DW-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= RST;
      active_o <= RST;
    end else if (srst_i) begin
      shadow_o <= RST;
      active_o <= RST;
    end else begin
      if (wr_i)     shadow_o <= wdata_i;
      if (commit_i) active_o <= shadow_o;
    end
  end
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
  import cfg_bank_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned AW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BW-1:0]     rd_data_o,
  output logic [1:0]        pwr_mode_o,
  output logic              pdwn_stby_o,
  output logic              dcs_off_o,
  output logic [BW-1:0]     rate_act_o,
  output logic [NCH*BW-1:0] chan_cfg_o
);
  localparam logic [NCH-1:0] IDX_RST = {NCH{1'b1}};

  logic            wr_port, wr_index, wr_pwr, wr_clk, wr_chcfg, wr_rate, wr_xfer;
  logic            srst_req, xfer_go;
  logic            lsb_q, pin_stby_q, dcs_off_q;
  logic [NCH-1:0]  idx_q;
  pwr_mode_e       pm_q;
  logic [BW-1:0]   ch_rd, rate_shadow;

  assign wr_port  = wr_en_i && (wr_addr_i == AW'(A_PORT));
  assign wr_index = wr_en_i && (wr_addr_i == AW'(A_INDEX));
  assign wr_pwr   = wr_en_i && (wr_addr_i == AW'(A_PWR));
  assign wr_clk   = wr_en_i && (wr_addr_i == AW'(A_CLK));
  assign wr_chcfg = wr_en_i && (wr_addr_i == AW'(A_CHCFG));
  assign wr_rate  = wr_en_i && (wr_addr_i == AW'(A_RATE));
  assign wr_xfer  = wr_en_i && (wr_addr_i == AW'(A_XFER));

  // either mirrored copy triggers the action
  assign srst_req = wr_port && (wr_data_i[5] || wr_data_i[2]);
  assign xfer_go  = wr_xfer && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q      <= 1'b0;
      idx_q      <= IDX_RST;
      pm_q       <= PM_RUN;
      pin_stby_q <= 1'b0;
      dcs_off_q  <= 1'b1;
    end else if (srst_req) begin
      lsb_q      <= 1'b0;
      idx_q      <= IDX_RST;
      pm_q       <= PM_RUN;
      pin_stby_q <= 1'b0;
      dcs_off_q  <= 1'b1;
    end else begin
      if (wr_port)  lsb_q <= wr_data_i[6] || wr_data_i[1];
      if (wr_index) idx_q <= wr_data_i[NCH-1:0];
      if (wr_pwr) begin
        pm_q       <= pwr_mode_e'(wr_data_i[1:0]);
        pin_stby_q <= wr_data_i[5];
      end
      if (wr_clk)   dcs_off_q <= wr_data_i[0];
    end
  end

  cfg_chan_bank #(.NCH(NCH), .DW(BW)) i_chan_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_req),
    .wr_i    (wr_chcfg),
    .sel_i   (idx_q),
    .wdata_i (wr_data_i),
    .flat_o  (chan_cfg_o),
    .rd_o    (ch_rd)
  );

  cfg_shadow_pair #(.DW(BW), .RST('0)) i_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst_req),
    .wr_i     (wr_rate),
    .commit_i (xfer_go),
    .wdata_i  (wr_data_i),
    .shadow_o (rate_shadow),
    .active_o (rate_act_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(A_PORT):  rd_data_o = PORT_FIXED | {1'b0, lsb_q, 4'b0000, lsb_q, 1'b0};
      AW'(A_ID):    rd_data_o = CHIP_ID;
      AW'(A_GRADE): rd_data_o = GRADE_VAL;
      AW'(A_INDEX): rd_data_o[NCH-1:0] = idx_q;
      AW'(A_PWR):   rd_data_o = {2'b00, pin_stby_q, 3'b000, pm_q};
      AW'(A_CLK):   rd_data_o = {7'b0, dcs_off_q};
      AW'(A_CHCFG): rd_data_o = ch_rd;
      AW'(A_RATE):  rd_data_o = rate_shadow;
      default:      rd_data_o = '0;
    endcase
  end

  assign pwr_mode_o  = pm_q;
  assign pdwn_stby_o = pin_stby_q;
  assign dcs_off_o   = dcs_off_q;
endmodule

// File: rtl/cfg_bank_regs_chk.sv
module cfg_bank_regs_chk #(
  parameter int unsigned NCH = 6,
  parameter int unsigned AW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [AW-1:0]     rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic [1:0]        pwr_mode_o,
  input logic              dcs_off_o,
  input logic [7:0]        rate_act_o,
  input logic [NCH*8-1:0]  chan_cfg_o,
  input logic [NCH-1:0]    idx_q
);
  logic port_wr, srst_wr, xfer_wr, ch_wr;
  assign port_wr = wr_en_i && (wr_addr_i == AW'(16'h0000));
  assign srst_wr = port_wr && (wr_data_i[5] || wr_data_i[2]);
  assign xfer_wr = wr_en_i && (wr_addr_i == AW'(16'h00FF)) && wr_data_i[0];
  assign ch_wr   = wr_en_i && (wr_addr_i == AW'(16'h0014));

  AST_PORT_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(0)) |-> (rd_data_o[4:3] == 2'b11 && !rd_data_o[0] && !rd_data_o[7])); // R1
  AST_PORT_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(0)) |-> (rd_data_o[6] == rd_data_o[1] && !rd_data_o[5] && !rd_data_o[2])); // R2
  AST_SRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_wr |=> (pwr_mode_o == 2'b00 && dcs_off_o && rate_act_o == 8'h00 && chan_cfg_o == '0)); // R3
  AST_CHIP_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(1)) |-> (rd_data_o == 8'hB5)); // R4
  AST_GRADE_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(2)) |-> (rd_data_o == 8'h60)); // R5
  AST_MASK_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_wr && idx_q == '0 && !srst_wr) |=> $stable(chan_cfg_o)); // R7
  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_wr || srst_wr) |=> $stable(rate_act_o)); // R8
  AST_XFER_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == AW'(16'h00FF)) |-> (rd_data_o == 8'h00)); // R8
endmodule

bind cfg_bank_regs cfg_bank_regs_chk #(.NCH(NCH), .AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .pwr_mode_o (pwr_mode_o),
  .dcs_off_o  (dcs_off_o),
  .rate_act_o (rate_act_o),
  .chan_cfg_o (chan_cfg_o),
  .idx_q      (idx_q)
);

// File: tb/test_cfg_bank_regs.sv
module test_cfg_bank_regs;
  localparam int NCH = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [15:0]     wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [15:0]     rd_addr = '0;
  logic [7:0]      rd_data;
  logic [1:0]      pwr_mode;
  logic            pdwn_stby, dcs_off;
  logic [7:0]      rate_act;
  logic [NCH*8-1:0] chan_cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [NCH];

  always #2 clk = ~clk;

  cfg_bank_regs #(.NCH(NCH), .AW(16)) i_cfg_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwr_mode_o(pwr_mode), .pdwn_stby_o(pdwn_stby), .dcs_off_o(dcs_off),
    .rate_act_o(rate_act), .chan_cfg_o(chan_cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [7:0] ch_expect(input logic [5:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return model[i];
    return 8'h00;
  endfunction

  function automatic logic [NCH*8-1:0] flat_expect();
    logic [NCH*8-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check_defaults(input string req);
    logic [7:0] v;
    rd(16'h0000, v); chk(req, v, 8'h18);
    rd(16'h0005, v); chk(req, v, 8'h3F);
    rd(16'h0008, v); chk(req, v, 8'h00);
    rd(16'h0009, v); chk(req, v, 8'h01);
    rd(16'h0100, v); chk(req, v, 8'h00);
    chk(req, rate_act, 8'h00);
    chk(req, chan_cfg, '0);
    chk(req, {pwr_mode, pdwn_stby, dcs_off}, 4'b0001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < NCH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check_defaults("R1 R6 R9 R10 reset");

    // R4 R5: identification, writes ignored
    wr(16'h0001, 8'h00); rd(16'h0001, v); chk("R4", v, 8'hB5);
    wr(16'h0002, 8'hFF); rd(16'h0002, v); chk("R5", v, 8'h60);

    // R1 R2: port configuration sweep without soft reset bits
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b = 8'(d);
      if (b[5] || b[2]) continue;
      wr(16'h0000, b);
      rd(16'h0000, v);
      chk("R2", v, 8'h18 | ((b[6] || b[1]) ? 8'h42 : 8'h00));
    end

    // R9 R12: power register sweep with mask cleared
    wr(16'h0005, 8'h00);
    for (int d = 0; d < 256; d++) begin
      wr(16'h0008, 8'(d));
      rd(16'h0008, v);
      chk("R9", v, 8'(d) & 8'h23);
      chk("R12", {pwr_mode, pdwn_stby}, {2'(d), d[5]});
    end
    wr(16'h0009, 8'hFE); rd(16'h0009, v); chk("R10", {v, 7'b0, dcs_off}, 16'h0000);
    wr(16'h0009, 8'h81); rd(16'h0009, v); chk("R10 R12", {v, 7'b0, dcs_off}, 16'h0101);

    // R6 R7: every channel mask
    for (int m = 0; m < 64; m++) begin
      logic [7:0] d = 8'(8'h40 + 3 * m);
      wr(16'h0005, 8'(m) | 8'hC0);
      rd(16'h0005, v); chk("R6", v, 8'(m));
      wr(16'h0014, d);
      for (int i = 0; i < NCH; i++) if (m[i]) model[i] = d;
      chk("R7 copies", chan_cfg, flat_expect());
      rd(16'h0014, v); chk("R7 read", v, ch_expect(6'(m)));
    end

    // R8: shadow and transfer
    wr(16'h0100, 8'h5A);
    chk("R8 no commit", rate_act, 8'h00);
    rd(16'h0100, v); chk("R8 shadow", v, 8'h5A);
    wr(16'h00FF, 8'hFE); chk("R8 bit0 clear", rate_act, 8'h00);
    wr(16'h00FF, 8'h01); chk("R8 commit", rate_act, 8'h5A);
    rd(16'h00FF, v); chk("R8 xfer reads 0", v, 8'h00);
    wr(16'h0100, 8'h33); chk("R8 hold", rate_act, 8'h5A);

    // R11: unmapped addresses
    for (int a = 0; a < 512; a++) begin
      logic [15:0] ad = 16'(a);
      if (ad inside {16'h0000, 16'h0001, 16'h0002, 16'h0005, 16'h0008,
                     16'h0009, 16'h0014, 16'h0100}) continue;
      rd(ad, v); chk("R11", v, 8'h00);
    end

    // R3: soft reset through bit 5, then through bit 2
    wr(16'h0000, 8'h42);
    wr(16'h0008, 8'h22);
    wr(16'h0000, 8'h20);
    for (int i = 0; i < NCH; i++) model[i] = 8'h00;
    check_defaults("R3 bit5");
    wr(16'h0005, 8'h01); wr(16'h0014, 8'h77);
    wr(16'h0100, 8'h11); wr(16'h00FF, 8'h01);
    wr(16'h0009, 8'h00);
    wr(16'h0000, 8'h04);
    check_defaults("R3 bit2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule